// File: doc/BRIEF.md
# Register-Driven MDIO Management Master

This block drives a two-wire management bus (MDC clock, bidirectional MDIO data) from two 32-bit host registers. The host first programs the configuration register with a clock divisor, a preamble enable and a field-layout select. It then writes a frame word to the frame register, which starts one management frame. The block serialises the start, opcode, PHY address, register address, turnaround and 16 data bits, MSB first. A 32-bit run of ones precedes them when the preamble is enabled. On a read frame the block releases MDIO from the turnaround onwards and captures 16 bits from the PHY.

When the last bit ends, a completion flag in the configuration register rises. For a read, the captured data then replaces the low half of the frame register. The host reads the registers back at any time. It clears the completion flag by rewriting the configuration register, typically with zero. Two layouts of the frame word are supported: a legacy layout that carries the PHY address in the word, and a newer layout in which the word carries a 5-bit register address and the PHY address comes from a build-time parameter.

Top module: `mdio_master`

## Requirements
- R1: After reset, the configuration readback and the frame readback are 0, MDC is low, MDIO is not driven (output enable 0) and the MDIO output value is 1.
- R2: A frame-register write (wrSel=1) while no frame is running stores the word, which reads back on dataOut, and starts a frame on the next cycle.
- R3: With configuration bit 7 set, the frame is preceded by exactly 32 MDC periods with MDIO driven to 1. With bit 7 clear there is no preamble.
- R4: The 32 frame bits leave MSB first in this order: start = word[31:30], opcode = word[29:28], PHY address (5), register address (5), turnaround = word[17:16], data = word[15:0]. Each bit is stable while MDC is high.
- R5: With configuration bit 9 clear (legacy layout), PHY address = word[26:22] and register address = {0, word[21:18]}. With bit 9 set (newer layout), PHY address = parameter PHY_ADDR and register address = word[22:18].
- R6: Every bit lasts 2·D clock cycles: MDC is low for D cycles, then high for D cycles. D is configuration bits [6:0], and a value of 0 is treated as 1.
- R7: For a read frame (word bit 29 = 1), MDIO is released from the first turnaround bit to the end. The 16 data bits are sampled on rising MDC. At completion, dataOut = {word[31:16], sampled data}.
- R8: Configuration bit 8 (done) goes high exactly 2·D·(32 + 32·preamble) clock edges after the edge that accepted the frame write. It is 0 one edge before.
- R9: A configuration write (wrSel=0) clears done. If it falls on the completion edge, done ends up set.
- R10: A frame-register write while a frame is running is ignored: dataOut, the bits on the wire and the completion timing are unchanged.
- R11: The divisor, preamble enable and layout are taken when the frame starts. A configuration write during a frame changes the readback but not the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Host register write strobe |
| wrSel | input | 1 | 0 = configuration register, 1 = frame register |
| wrData | input | 32 | Host write data |
| ctrlOut | output | 32 | Configuration readback: [6:0] divisor, [7] preamble, [8] done, [9] layout |
| dataOut | output | 32 | Frame register readback |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value when driven |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value from the pin |

## Verification
Two functions can act on the done flag in the same cycle: completion setting it and a host configuration write clearing it. The bench computes the exact completion edge from the divisor and the preamble setting. It places a configuration write on that edge and expects done to read 1 afterwards. A second overlap, a frame-register write landing mid-frame, is provoked the same way. It is judged by the unchanged wire bits, timing and readback.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 32;
  localparam int PRE_LEN   = 32;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int TA_IDX    = 14;
  localparam int DATA_IDX  = 16;

  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
    logic finish;
  } mdioStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_FRAME
  } mdioState_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataWr,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             cfgPre,
  input  logic             wordRead,
  output mdioStrobe_t      strobe,
  output logic             busy,
  output logic             inFrame,
  output logic             mdc,
  output logic             oe
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);

  mdioState_t       state;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLat;
  logic [CNT_W-1:0] bitCnt;
  logic             mdcQ;
  logic             rdLat;
  logic             halfEnd;
  logic             start;
  logic             lastBit;

  assign start   = dataWr && (state == ST_IDLE);
  assign halfEnd = (state != ST_IDLE) && (divCnt == divLat - DIV_W'(1));
  assign lastBit = (bitCnt == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      divLat <= DIV_W'(1);
      bitCnt <= '0;
      mdcQ   <= 1'b0;
      rdLat  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= cfgPre ? ST_PRE : ST_FRAME;
            divLat <= (cfgDiv == '0) ? DIV_W'(1) : cfgDiv;
            rdLat  <= wordRead;
            divCnt <= '0;
            bitCnt <= '0;
            mdcQ   <= 1'b0;
          end
        end
        default: begin
          if (halfEnd) begin
            divCnt <= '0;
            mdcQ   <= ~mdcQ;
            if (mdcQ) begin
              if (lastBit) begin
                bitCnt <= '0;
                state  <= (state == ST_PRE) ? ST_FRAME : ST_IDLE;
              end else begin
                bitCnt <= bitCnt + CNT_W'(1);
              end
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.load   = start;
    strobe.shift  = (state == ST_FRAME) && halfEnd && mdcQ && !lastBit;
    strobe.finish = (state == ST_FRAME) && halfEnd && mdcQ && lastBit;
    strobe.sample = (state == ST_FRAME) && halfEnd && !mdcQ && rdLat &&
                    (bitCnt >= CNT_W'(DATA_IDX));
  end

  assign busy    = (state != ST_IDLE);
  assign inFrame = (state == ST_FRAME);
  assign mdc     = mdcQ;
  assign oe      = (state == ST_PRE) ||
                   ((state == ST_FRAME) && (!rdLat || (bitCnt < CNT_W'(TA_IDX))));
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int         DIV_W    = 7,
  parameter logic [4:0] PHY_ADDR = 5'd0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [31:0]      wrData,
  input  mdioStrobe_t      strobe,
  input  logic             inFrame,
  input  logic             mdioIn,
  output logic [DIV_W-1:0] cfgDiv,
  output logic             cfgPre,
  output logic [31:0]      ctrlOut,
  output logic [31:0]      dataOut,
  output logic             mdioOut
);
  localparam int PRE_BIT    = 7;
  localparam int DONE_BIT   = 8;
  localparam int LAYOUT_BIT = 9;

  logic [DIV_W-1:0] divQ;
  logic             preQ;
  logic             layoutQ;
  logic             doneQ;
  logic [31:0]      dataQ;
  logic [31:0]      shiftQ;
  logic [15:0]      capQ;
  logic             frameRead;
  logic [4:0]       phyField;
  logic [4:0]       regField;
  logic [31:0]      frameWord;

  always_comb begin
    if (layoutQ) begin
      phyField = PHY_ADDR;
      regField = wrData[22:18];
    end else begin
      phyField = wrData[26:22];
      regField = {1'b0, wrData[21:18]};
    end
    frameWord = {wrData[31:30], wrData[29:28], phyField, regField,
                 wrData[17:16], wrData[15:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ    <= '0;
      preQ    <= 1'b0;
      layoutQ <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      if (cfgWr) begin
        divQ    <= wrData[DIV_W-1:0];
        preQ    <= wrData[PRE_BIT];
        layoutQ <= wrData[LAYOUT_BIT];
      end
      if (strobe.finish) begin
        doneQ <= 1'b1;
      end else if (cfgWr) begin
        doneQ <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ     <= '0;
      shiftQ    <= '0;
      capQ      <= '0;
      frameRead <= 1'b0;
    end else begin
      if (strobe.load) begin
        dataQ     <= wrData;
        shiftQ    <= frameWord;
        frameRead <= wrData[29];
      end else begin
        if (strobe.shift) begin
          shiftQ <= {shiftQ[30:0], 1'b0};
        end
        if (strobe.sample) begin
          capQ <= {capQ[14:0], mdioIn};
        end
        if (strobe.finish && frameRead) begin
          dataQ[15:0] <= capQ;
        end
      end
    end
  end

  always_comb begin
    ctrlOut                  = '0;
    ctrlOut[DIV_W-1:0]       = divQ;
    ctrlOut[PRE_BIT]         = preQ;
    ctrlOut[DONE_BIT]        = doneQ;
    ctrlOut[LAYOUT_BIT]      = layoutQ;
  end

  assign dataOut = dataQ;
  assign mdioOut = inFrame ? shiftQ[31] : 1'b1;
  assign cfgDiv  = divQ;
  assign cfgPre  = preQ;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int         DIV_W    = 7,
  parameter logic [4:0] PHY_ADDR = 5'd0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [31:0] wrData,
  output logic [31:0] ctrlOut,
  output logic [31:0] dataOut,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioStrobe_t      strobe;
  logic             busy;
  logic             inFrame;
  logic [DIV_W-1:0] cfgDiv;
  logic             cfgPre;
  logic             dataWr;
  logic             cfgWr;

  assign dataWr = wrEn && wrSel;
  assign cfgWr  = wrEn && !wrSel;

  mdio_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .dataWr   (dataWr),
    .cfgDiv   (cfgDiv),
    .cfgPre   (cfgPre),
    .wordRead (wrData[29]),
    .strobe   (strobe),
    .busy     (busy),
    .inFrame  (inFrame),
    .mdc      (mdc),
    .oe       (mdioOe)
  );

  mdio_dp #(.DIV_W(DIV_W), .PHY_ADDR(PHY_ADDR)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWr   (cfgWr),
    .wrData  (wrData),
    .strobe  (strobe),
    .inFrame (inFrame),
    .mdioIn  (mdioIn),
    .cfgDiv  (cfgDiv),
    .cfgPre  (cfgPre),
    .ctrlOut (ctrlOut),
    .dataOut (dataOut),
    .mdioOut (mdioOut)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        wrSel,
  input logic [31:0] ctrlOut,
  input logic [31:0] dataOut,
  input logic        mdc,
  input logic        mdioOe,
  input logic        busy,
  input mdioStrobe_t strobe
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe)) else $error("idle bus not quiet"); // R1

  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sample |-> !mdioOe) else $error("sampling while driving"); // R7

  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> ctrlOut[8]) else $error("done missing"); // R9

  AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel && !strobe.finish) |=> !ctrlOut[8]) else $error("done not cleared"); // R9

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && wrSel && !strobe.finish) |=> $stable(dataOut)) else $error("busy write taken"); // R10

  AST_NO_DOUBLE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.load, strobe.shift, strobe.finish}) <= 1) else $error("strobe clash"); // R2
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrSel   (wrSel),
  .ctrlOut (ctrlOut),
  .dataOut (dataOut),
  .mdc     (mdc),
  .mdioOe  (mdioOe),
  .busy    (busy),
  .strobe  (strobe)
);

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  localparam logic [4:0] PHY_P = 5'd3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] ctrlOut;
  logic [31:0] dataOut;
  logic        mdc;
  logic        mdioOut;
  logic        mdioOe;
  logic        mdioIn = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] phyResp;
  int          phyOff;
  int          fallCnt;
  int          riseCnt;
  logic        capOut [0:63];
  logic        capOe  [0:63];

  always #10 clk = ~clk;

  mdio_master #(.PHY_ADDR(PHY_P)) u_mdio_master (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .ctrlOut(ctrlOut), .dataOut(dataOut), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always @(posedge mdc) begin
    if (riseCnt < 64) begin
      capOut[riseCnt] = mdioOut;
      capOe[riseCnt]  = mdioOe;
    end
    riseCnt = riseCnt + 1;
  end

  always @(negedge mdc) begin
    int idx;
    fallCnt = fallCnt + 1;
    idx = fallCnt - phyOff - 16;
    if (idx >= 0 && idx < 16) mdioIn = phyResp[15 - idx];
    else mdioIn = 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expFrame(input logic [31:0] w, input bit newLayout);
    logic [4:0] p;
    logic [4:0] r;
    p = newLayout ? PHY_P : w[26:22];
    r = newLayout ? w[22:18] : {1'b0, w[21:18]};
    return {w[31:30], w[29:28], p, r, w[17:16], w[15:0]};
  endfunction

  task automatic hostWrite(input bit sel, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // mode 0 plain, 1 frame write mid-frame, 2 config write mid-frame, 3 config write on completion edge
  task automatic runFrame(input logic [31:0] cfg, input logic [31:0] word, input logic [15:0] resp, input int mode);
    int d, n, total, rdFrame;
    logic [31:0] fr;
    bit bitsOk, oeOk, preOk;
    hostWrite(1'b0, cfg);
    d = (cfg[6:0] == 0) ? 1 : int'(cfg[6:0]);
    n = cfg[7] ? 64 : 32;
    total = 2 * d * n;
    rdFrame = word[29];
    fr = expFrame(word, cfg[9]);
    phyResp = resp; phyOff = cfg[7] ? 32 : 0; fallCnt = 0; riseCnt = 0; mdioIn = 1'b1;
    wrEn = 1'b1; wrSel = 1'b1; wrData = word;
    @(posedge clk);
    for (int k = 1; k <= total; k++) begin
      @(negedge clk);
      wrEn = 1'b0;
      if (k == 1) check(dataOut == word, "R2 readback", dataOut, word);
      if (k == total) check(ctrlOut[8] == 1'b0, "R8 done early", {31'b0, ctrlOut[8]}, 32'd0);
      if (mode == 1 && k == total / 2) begin wrEn = 1'b1; wrSel = 1'b1; wrData = ~word; end
      if (mode == 2 && k == total / 2) begin wrEn = 1'b1; wrSel = 1'b0; wrData = cfg ^ 32'h0000_0003; end
      if (mode == 3 && k == total) begin wrEn = 1'b1; wrSel = 1'b0; wrData = cfg; end
      @(posedge clk);
    end
    @(negedge clk);
    wrEn = 1'b0;
    check(ctrlOut[8] == 1'b1, (mode == 3) ? "R9 collision" : "R8 done", {31'b0, ctrlOut[8]}, 32'd1);
    check(riseCnt == n, "R6 mdc periods", riseCnt, n);
    preOk = 1; bitsOk = 1; oeOk = 1;
    for (int i = 0; i < n && i < 64; i++) begin
      if (i < phyOff) begin
        if (capOut[i] !== 1'b1 || capOe[i] !== 1'b1) preOk = 0;
      end else begin
        int j;
        bit expOe;
        j = i - phyOff;
        expOe = rdFrame ? (j < 14) : 1'b1;
        if (capOe[i] !== expOe) oeOk = 0;
        if (expOe && capOut[i] !== fr[31 - j]) bitsOk = 0;
      end
    end
    if (cfg[7]) check(preOk, "R3 preamble", {31'b0, preOk}, 32'd1);
    check(bitsOk, cfg[9] ? "R5 new layout bits" : "R4 R5 legacy bits", {31'b0, bitsOk}, 32'd1);
    check(oeOk, "R7 output enable", {31'b0, oeOk}, 32'd1);
    if (rdFrame) check(dataOut == {word[31:16], resp}, "R7 read data", dataOut, {word[31:16], resp});
    else check(dataOut == word, (mode == 1) ? "R10 busy write" : "R2 write data", dataOut, word);
    if (mode == 2) check(ctrlOut[6:0] == (cfg[6:0] ^ 7'h3), "R11 cfg readback", ctrlOut, cfg ^ 32'h3);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ctrlOut == 0 && dataOut == 0, "R1 regs", ctrlOut ^ dataOut, 32'd0);
    check(!mdc && !mdioOe && mdioOut, "R1 pins", {29'b0, mdc, mdioOe, mdioOut}, 32'd1);
    rstN = 1'b1;
    // directed corners
    runFrame(32'h0000_0000, 32'h5A95_ABCD, 16'h0, 0);   // R6 divisor 0 -> 1, legacy write
    runFrame(32'h0000_0082, 32'h6BFE_0000, 16'hC3A5, 0); // R3 preamble, read
    runFrame(32'h0000_0202, 32'h6A7E_0000, 16'h1234, 0); // R5 new layout read
    runFrame(32'h0000_0003, 32'h5412_9876, 16'h0, 1);   // R10
    runFrame(32'h0000_0082, 32'h5555_F00F, 16'h0, 2);   // R11
    runFrame(32'h0000_0002, 32'h6000_0000, 16'hBEEF, 3); // R9
    runFrame(32'h0000_0281, 32'h5000_0001, 16'h0, 3);   // R9 with preamble
    for (int t = 0; t < 24; t++) begin
      logic [31:0] cfg;
      logic [31:0] word;
      cfg  = ($urandom % 4) | (($urandom % 2) << 7) | (($urandom % 2) << 9);
      word = $urandom;
      word[31:28] = ($urandom % 2) ? 4'b0110 : 4'b0101;
      runFrame(cfg, word, 16'($urandom), $urandom % 4);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule